// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block supplies the address for a four-beat memory burst. A full start address is captured whenever either of two active-low load strobes is low at a rising clock edge. After that, every rising edge with the active-low advance input low moves the burst one beat forward. The upper address bits stay as they were captured. Only the two low bits walk through the burst.

The walk order is chosen by a mode input that is not registered. With the mode high, the low bits count upward from the start value and wrap modulo four. With the mode low, the low bits are the start value XOR the beat number. The block holds a base register and a two-bit beat counter, and it maps them to an address combinationally. A change of mode therefore shows on the output without waiting for a clock edge. The full address drives the memory core directly.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is active, and after its synchronous release with no strobe or advance, the output address is all zeros.
- R2: A low level on `load_a_n` at a rising edge captures all of `addr_in`. The output equals that value after the edge, at beat 0.
- R3: A low level on `load_b_n` at a rising edge captures `addr_in` in the same way, with the same result as R2.
- R4: With `order_lin` = 1 (linear), each advance (`step_n` low, both strobes high) makes the low two bits (start + beat) mod 4.
- R5: With `order_lin` = 0 (interleaved), the low two bits are start XOR beat, where beat counts 0, 1, 2, 3.
- R6: With both strobes high and `step_n` high at an edge, the output address does not change.
- R7: If a strobe is low while `step_n` is also low, the load wins. The output becomes the new `addr_in` at beat 0.
- R8: Between loads, bits above bit 1 of the output never change.
- R9: The fourth advance after a load brings the low bits back to the loaded start value, and the walk then repeats.
- R10: A change of `order_lin` between clock edges changes the low bits of the output within the same cycle. The beat position is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_a_n | input | 1 | First active-low load strobe |
| load_b_n | input | 1 | Second active-low load strobe |
| step_n | input | 1 | Active-low burst advance |
| order_lin | input | 1 | Burst order, not registered: 1 linear, 0 interleaved |
| addr_in | input | ADDR_W | Start address captured on a load |
| addr_out | output | ADDR_W | Current burst address to the memory core |

## Verification
A load or an advance shows on `addr_out` one edge after it is presented, because the base register and beat counter are the only registers on that path. The bench drives inputs 2 ns after a rising edge and checks 2 ns after the next one, so each check sees exactly one register update. A change of `order_lin` is due with no edge at all, so the bench checks it 1 ns after the change, in the middle of the cycle. Reset release takes two extra edges in the internal synchronizer, and the bench waits for them before it applies any stimulus.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  typedef enum logic {
    ORD_XOR = 1'b0,
    ORD_INC = 1'b1
  } burst_order_e;

  localparam int unsigned DEF_ADDR_W    = 18;
  localparam int unsigned DEF_BURST_LEN = 4;
endpackage

// File: rtl/bsq_rst_sync.sv
module bsq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bsq_base_reg.sv
module bsq_base_reg #(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base_q
);
  logic [ADDR_W-1:0] base_d;

  always_comb begin
    base_d = base_q;
    if (load) base_d = addr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end
endmodule

// File: rtl/bsq_beat_ctr.sv
module bsq_beat_ctr #(
  parameter int unsigned BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  output logic [BEAT_W-1:0] beat_q
);
  logic [BEAT_W-1:0] beat_d;
  logic              beat_en;

  // clock enable: load has priority over step
  assign beat_en = load | step;

  always_comb begin
    beat_d = beat_q;
    if (load)      beat_d = '0;
    else if (step) beat_d = beat_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat_q <= '0;
    else if (beat_en) beat_q <= beat_d;
  end
endmodule

// File: rtl/bsq_order_map.sv
module bsq_order_map #(
  parameter int unsigned BEAT_W = 2
) (
  input  logic              order_lin,
  input  logic [BEAT_W-1:0] start_lo,
  input  logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] addr_lo
);
  import bsq_pkg::*;

  logic [BEAT_W-1:0] lin_lo;
  logic [BEAT_W-1:0] xor_lo;

  // linear order wraps naturally at the counter width
  assign lin_lo = start_lo + beat;

  for (genvar g = 0; g < BEAT_W; g++) begin : g_xor_bit
    assign xor_lo[g] = start_lo[g] ^ beat[g];
  end

  always_comb begin
    unique case (burst_order_e'(order_lin))
      ORD_INC: addr_lo = lin_lo;
      default: addr_lo = xor_lo;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int unsigned ADDR_W    = bsq_pkg::DEF_ADDR_W,
  parameter int unsigned BURST_LEN = bsq_pkg::DEF_BURST_LEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_a_n,
  input  logic              load_b_n,
  input  logic              step_n,
  input  logic              order_lin,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int unsigned BEAT_W = $clog2(BURST_LEN);

  logic              rst_core_n;
  logic              load;
  logic              step;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] addr_lo;

  assign load = ~load_a_n | ~load_b_n;
  assign step = ~step_n;

  bsq_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  bsq_base_reg #(.ADDR_W(ADDR_W)) i_base (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .load    (load),
    .addr_in (addr_in),
    .base_q  (base_q)
  );

  bsq_beat_ctr #(.BEAT_W(BEAT_W)) i_beat (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .load   (load),
    .step   (step),
    .beat_q (beat_q)
  );

  bsq_order_map #(.BEAT_W(BEAT_W)) i_map (
    .order_lin (order_lin),
    .start_lo  (base_q[BEAT_W-1:0]),
    .beat      (beat_q),
    .addr_lo   (addr_lo)
  );

  assign addr_out = {base_q[ADDR_W-1:BEAT_W], addr_lo};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_a_n,
  input logic              load_b_n,
  input logic              step_n,
  input logic              order_lin,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out
);
  p_load_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_a_n |=> addr_out == $past(addr_in));

  p_load_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_b_n |=> addr_out == $past(addr_in));

  p_lin_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_a_n && load_b_n && !step_n && order_lin) |=>
      (!order_lin || addr_out[BEAT_W-1:0] == $past(addr_out[BEAT_W-1:0]) + 1'b1));

  p_xor_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_a_n && load_b_n && !step_n && !order_lin) |=>
      (order_lin || $countones(addr_out[BEAT_W-1:0] ^ $past(addr_out[BEAT_W-1:0])) != 0));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_a_n && load_b_n && step_n) |=>
      (!$stable(order_lin) || $stable(addr_out)));

  p_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_a_n && load_b_n) |=>
      addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W]));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .load_a_n  (load_a_n),
  .load_b_n  (load_b_n),
  .step_n    (step_n),
  .order_lin (order_lin),
  .addr_in   (addr_in),
  .addr_out  (addr_out)
);

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          load_a_n;
  logic          load_b_n;
  logic          step_n;
  logic          order_lin;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] addr_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BURST_LEN(4)) i_burst_addr_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_a_n  (load_a_n),
    .load_b_n  (load_b_n),
    .step_n    (step_n),
    .order_lin (order_lin),
    .addr_in   (addr_in),
    .addr_out  (addr_out)
  );

  task automatic chk(input string req, input logic [AW-1:0] exp);
    checks++;
    if (addr_out !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, addr_out, exp);
    end
  endtask

  // one edge, then settle 2 ns
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  function automatic logic [1:0] lo_exp(input logic [1:0] s, input int b, input logic lin);
    return lin ? 2'(s + b) : 2'(s ^ b);
  endfunction

  task automatic load_burst(input bit use_b, input logic [AW-1:0] a, input logic adv);
    load_a_n = use_b;
    load_b_n = !use_b;
    step_n   = !adv;
    addr_in  = a;
    tick();
    load_a_n = 1'b1;
    load_b_n = 1'b1;
    step_n   = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    load_a_n = 1'b1; load_b_n = 1'b1; step_n = 1'b1;
    order_lin = 1'b1; addr_in = '0;
    repeat (3) tick();
    chk("R1 in reset", '0);
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R1 after release", '0);

    // sweep: strobe, order, start low bits, with five advances each (wrap)
    for (int sb = 0; sb < 2; sb++) begin
      for (int m = 0; m < 2; m++) begin
        for (int s = 0; s < 4; s++) begin
          logic [AW-1:0] a;
          a = {16'(16'h5A3C + 16'(s * 97 + m * 13 + sb)), 2'(s)};
          order_lin = logic'(m);
          load_burst(sb[0], a, 1'b0);
          chk(sb ? "R3 load" : "R2 load", a);
          for (int b = 1; b <= 5; b++) begin
            step_n = 1'b0;
            tick();
            step_n = 1'b1;
            chk(m ? "R4 linear step" : "R5 xor step",
                {a[AW-1:2], lo_exp(2'(s), b, logic'(m))});
            if (b == 4) chk("R9 wrap to start", a);
            chk("R8 upper kept", {a[AW-1:2], addr_out[1:0]});
          end
          tick();
          chk("R6 hold", {a[AW-1:2], lo_exp(2'(s), 5, logic'(m))});
          tick();
          chk("R6 hold again", {a[AW-1:2], lo_exp(2'(s), 5, logic'(m))});
        end
      end
    end

    // priority: strobe with advance mid-burst
    order_lin = 1'b1;
    load_burst(1'b0, 18'h2_AAA9, 1'b0);
    step_n = 1'b0; tick(); step_n = 1'b1;
    chk("R4 pre-priority", 18'h2_AAAA);
    load_burst(1'b1, 18'h1_2346, 1'b1);
    chk("R7 load beats advance", 18'h1_2346);
    load_burst(1'b0, 18'h3_0003, 1'b1);
    chk("R7 load A with advance", 18'h3_0003);

    // asynchronous mode change at beat 2, start 1
    load_burst(1'b0, 18'h0_F001, 1'b0);
    step_n = 1'b0; tick(); tick(); step_n = 1'b1;
    chk("R4 beat2 linear", 18'h0_F003);
    #1 order_lin = 1'b0;
    #1 chk("R10 switch to xor", 18'h0_F003);
    order_lin = 1'b1;
    step_n = 1'b0; tick(); step_n = 1'b1;
    chk("R10 beat3 linear", 18'h0_F000);
    #1 order_lin = 1'b0;
    #1 chk("R10 beat3 xor", 18'h0_F002);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule